// File: doc/BRIEF.md
# Shared-Bus Three-Register Transfer Unit

The block holds three registers of parameterised width that exchange data over one common bus. A two-bit source code picks which register drives the bus in a given cycle, and three separate write enables pick which registers capture the bus value at the rising clock edge. Because only one source can drive the bus, several registers may take the same value in one cycle. Two different source values can never be moved in the same cycle.

The bus value is combinational from the source code and the current register contents, and it is brought out together with all three registers. Reset is synchronous and active high, and it clears every register.

Top module: `bus_xfer3`

## Requirements
- R1: While `rst` is high at a rising edge, all three registers become zero.
- R2: Source code 0 (binary 00) puts register 0 on `bus`, code 1 (01) puts register 1, and code 2 (10) puts register 2. The bus follows in the same cycle, with no clock edge in between.
- R3: Source code 3 (binary 11) drives all zeros on `bus`.
- R4: At a rising edge, a register whose enable is high takes the value `bus` held just before that edge. Enable bit 0 of `wr_en` belongs to register 0, bit 1 to register 1 and bit 2 to register 2.
- R5: A register whose enable is low keeps its contents, whatever the source code is.
- R6: When several enables are high, each enabled register receives the same single bus value in one edge. A register that is both source and destination keeps its value.
- R7: Registers can only be preset through the bus. Loading from source code 3 clears the enabled registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Bus source code |
| wr_en | input | 3 | Per-register write enables |
| seed | input | W | Value driven onto the bus when `seed_en` is high, used only to preset registers |
| seed_en | input | 1 | Replaces the bus source with `seed` |
| reg0 | output | W | Register 0 contents |
| reg1 | output | W | Register 1 contents |
| reg2 | output | W | Register 2 contents |
| bus | output | W | Current bus value |

## Verification
The registers are first preset to distinct values. The bench then sweeps every source code against every one of the eight enable patterns, and returns the registers to known distinct values before each step. Each step checks that exactly the enabled registers take the one bus value and that the others keep their contents. This separates a wrong source decode from a wrong enable mapping. Patterns where the source register is also a destination show that self-loads keep the value. Code 3 with enables shows that the zero bus clears registers, and a reset step in the middle of a run shows the synchronous clear.

// File: rtl/bus_xfer3.sv
module bus_xfer3 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   src_sel,
  input  logic [2:0]   wr_en,
  input  logic [W-1:0] seed,
  input  logic         seed_en,
  output logic [W-1:0] reg0,
  output logic [W-1:0] reg1,
  output logic [W-1:0] reg2,
  output logic [W-1:0] bus
);
  logic [W-1:0] r [3];
  logic [W-1:0] mux_out;

  always_comb begin
    unique case (src_sel)
      2'd0:    mux_out = r[0];
      2'd1:    mux_out = r[1];
      2'd2:    mux_out = r[2];
      default: mux_out = '0;
    endcase
  end

  assign bus = seed_en ? seed : mux_out;

  for (genvar i = 0; i < 3; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           r[i] <= '0;
      else if (wr_en[i]) r[i] <= bus;
    end
  end

  assign reg0 = r[0];
  assign reg1 = r[1];
  assign reg2 = r[2];
endmodule

module bus_xfer3_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   src_sel,
  input logic [2:0]   wr_en,
  input logic         seed_en,
  input logic [W-1:0] reg0,
  input logic [W-1:0] reg1,
  input logic [W-1:0] reg2,
  input logic [W-1:0] bus
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> (reg0 == '0 && reg1 == '0 && reg2 == '0));
  assert_bus_src_R2: assert property (@(posedge clk) disable iff (rst)
    (!seed_en && src_sel != 2'd3) |-> bus == (src_sel == 2'd0 ? reg0 : src_sel == 2'd1 ? reg1 : reg2));
  assert_bus_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!seed_en && src_sel == 2'd3) |-> bus == '0);
  assert_load0_R4: assert property (@(posedge clk) disable iff (rst) wr_en[0] |=> reg0 == $past(bus));
  assert_load2_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en[1] && wr_en[2]) |=> reg1 == reg2);
  assert_hold1_R5: assert property (@(posedge clk) disable iff (rst) !wr_en[1] |=> $stable(reg1));
endmodule

bind bus_xfer3 bus_xfer3_chk #(.W(W)) i_chk (.*);

// File: tb/test_bus_xfer3.sv
module test_bus_xfer3;
  localparam int W = 8;
  logic clk = 0, rst;
  logic [1:0] src_sel;
  logic [2:0] wr_en;
  logic [W-1:0] seed;
  logic seed_en;
  logic [W-1:0] reg0, reg1, reg2, bus;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_xfer3 #(.W(W)) i_bus_xfer3 (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic preset(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    seed_en = 1;
    seed = a; wr_en = 3'b001; tick();
    seed = b; wr_en = 3'b010; tick();
    seed = c; wr_en = 3'b100; tick();
    seed_en = 0; wr_en = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v [3];
    logic [W-1:0] b;
    rst = 1; src_sel = 0; wr_en = 0; seed = 0; seed_en = 0;
    #1; tick(); tick();
    rst = 0;
    chk("R1 reg0", reg0, 0); chk("R1 reg1", reg1, 0); chk("R1 reg2", reg2, 0);
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 8; e++) begin
        v[0] = 8'h11 + 8'(s*16 + e); v[1] = 8'h5a ^ 8'(e); v[2] = 8'hc3 - 8'(s);
        preset(v[0], v[1], v[2]);
        src_sel = 2'(s); #1;
        b = (s == 3) ? '0 : v[s];
        chk(s == 3 ? "R3 bus zero" : "R2 bus source", bus, b);
        wr_en = 3'(e); tick();
        chk(e[0] ? "R4 reg0 load" : "R5 reg0 hold", reg0, e[0] ? b : v[0]);
        chk(e[1] ? (e > 2 ? "R6 reg1 shared" : "R4 reg1 load") : "R5 reg1 hold", reg1, e[1] ? b : v[1]);
        chk(e[2] ? (s == 3 ? "R7 reg2 clear" : "R6 reg2 load") : "R5 reg2 hold", reg2, e[2] ? b : v[2]);
        wr_en = 0;
      end
    end
    preset(8'h01, 8'h02, 8'h03);
    rst = 1; wr_en = 3'b111; src_sel = 2; tick(); rst = 0; wr_en = 0;
    chk("R1 mid reset reg0", reg0, 0); chk("R1 mid reset reg1", reg1, 0); chk("R1 mid reset reg2", reg2, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule